// File: doc/BRIEF.md
# Accumulator ALU with status flags

This block is the execution datapath of a small 8-bit accumulator controller. Each instruction word arrives together with the working register W, the file operand already fetched by the surrounding logic, and the current status byte. In the same cycle the block returns a data result, one write strobe that sends it either to W or back to the file, a new status byte, and a request to skip the next instruction. It has no clock and no state: instruction fetch, the register file and program-counter handling stay in the enclosing core.

File operations take their operand from the file and sometimes from W. They cover add, subtract, increment and decrement (with and without skip-on-zero), OR, AND and XOR, complement, move, clear, rotate through carry and nibble swap. The literal forms combine an 8-bit constant with W. The status byte keeps carry in bit 0, digit carry in bit 1 and zero in bit 2. Each operation changes only its own subset of these three flags.

Top module: `acc_alu`

## Requirements
- R1: File operations take the opcode from bits 11..6, the destination from bit 5 and the file address from bits 4..0. Destination 0 raises `wr_w` and 1 raises `wr_f`. Literal operations always raise `wr_w`, and `wr_w` and `wr_f` are never high together.
- R2: Add (opcode 000111) gives f + W. Carry (status bit 0) is the carry out of bit 7, digit carry (bit 1) is the carry out of bit 3, and zero (bit 2) is set when the 8-bit result is 0.
- R3: Subtract (opcode 000010) gives f + ~W + 1. Carry, digit carry and zero follow the same rules as add, so carry = 1 means no borrow (f >= W).
- R4: Clear (000001, result 0), decrement (000011), OR (000100), AND (000101), XOR (000110), move (001000, result f), complement (001001) and increment (001010) update only the zero flag and leave carry and digit carry as they were.
- R5: Rotate right (001100) shifts f down one place, puts the old carry into bit 7 and the old bit 0 into carry. Rotate left (001101) shifts f up one place, puts the old carry into bit 0 and the old bit 7 into carry. Digit carry and zero are unchanged.
- R6: Swap (001110) exchanges the two nibbles of f and changes no flag.
- R7: Decrement-and-skip (001011) and increment-and-skip (001111) change no flag, and they raise `skip` exactly when their 8-bit result is 0. No other operation raises `skip`.
- R8: A literal operation has bits 11..10 = 11, and bits 7..0 hold the constant k. Bits 9..8 = 00 loads k into W with no flag change; 01, 10 and 11 give W OR k, W AND k and W XOR k, and these three update only zero.
- R9: Opcode 000000 with destination 1 writes W to the file and changes no flag. With destination 0 it is a no-operation, with no write.
- R10: Status output bits 7..3 are always 1, whatever the status input holds.
- R11: Words with bits 11..9 equal to 010, 011, 100 or 101 raise no write and no skip, and they pass carry, digit carry and zero through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 12 | Instruction word |
| w_in | input | 8 | Working register W |
| f_in | input | 8 | Selected file operand |
| status_in | input | 8 | Current status byte |
| result | output | 8 | Data result to be written |
| wr_w | output | 1 | Write result into W |
| wr_f | output | 1 | Write result back to the file |
| status_out | output | 8 | Next status byte |
| skip | output | 1 | Skip the next instruction |

## Verification
The hardest cases to reach are digit-carry boundaries on subtract, where the low nibbles of f and W are equal or differ by one. The same goes for the wrap points of the skip forms, where only f = 1 (decrement) or f = 255 (increment) raises skip. The sweep therefore builds its operand set from the corner values 00, 01, 0F, 10, 7F, 80, FE and FF plus spread values. It crosses every file opcode and both destinations with all eight carry, digit-carry and zero input combinations, so flags that are passed through are seen in both polarities.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int DW      = 8;
  localparam int IW      = 12;
  localparam int NIB     = DW / 2;
  localparam int HI_W    = DW - NIB;
  localparam int OPLO    = 6;
  localparam int DEST    = 5;
  localparam int C_BIT   = 0;
  localparam int DC_BIT  = 1;
  localparam int Z_BIT   = 2;
  localparam int FLAG_W  = 3;
  localparam int FIXED_W = DW - FLAG_W;

  typedef enum logic [4:0] {
    OP_NONE, OP_MOVWF, OP_CLR, OP_SUB, OP_DEC, OP_IOR, OP_AND, OP_XOR,
    OP_ADD, OP_MOV, OP_COM, OP_INC, OP_DECSZ, OP_RRF, OP_RLF, OP_SWAP,
    OP_INCSZ, OP_MOVL
  } op_e;

  typedef struct packed {
    op_e  op;
    logic wr_en;
    logic to_file;
    logic use_lit;
    logic upd_c;
    logic upd_dc;
    logic upd_z;
    logic may_skip;
  } ctl_t;

  // {carry out of top bit, carry out of low nibble, sum}
  function automatic logic [DW+1:0] add_carries(input logic [DW-1:0] a,
                                                input logic [DW-1:0] b,
                                                input logic          cin);
    logic [NIB:0]  lo;
    logic [HI_W:0] hi;
    lo = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]} + {{NIB{1'b0}}, cin};
    hi = {1'b0, a[DW-1:NIB]} + {1'b0, b[DW-1:NIB]} + {{HI_W{1'b0}}, lo[NIB]};
    return {hi[HI_W], lo[NIB], hi[HI_W-1:0], lo[NIB-1:0]};
  endfunction

  function automatic logic [DW-1:0] swap_nibbles(input logic [DW-1:0] x);
    return {x[NIB-1:0], x[DW-1:NIB]};
  endfunction

  // {carry out, rotated value}
  function automatic logic [DW:0] rot_right(input logic [DW-1:0] x, input logic c);
    return {x[0], c, x[DW-1:1]};
  endfunction

  function automatic logic [DW:0] rot_left(input logic [DW-1:0] x, input logic c);
    return {x[DW-1], x[DW-2:0], c};
  endfunction
endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
  import acc_alu_pkg::*;
(
  input  logic [IW-1:0] instr,
  output ctl_t          ctl
);
  logic       is_lit;
  logic       is_file;
  logic       dest;
  logic [3:0] sub_op;

  assign is_lit  = (instr[IW-1:IW-2] == 2'b11);
  assign is_file = (instr[IW-1:IW-2] == 2'b00);
  assign dest    = instr[DEST];
  assign sub_op  = instr[OPLO+3:OPLO];

  always_comb begin
    ctl    = '0;
    ctl.op = OP_NONE;
    if (is_lit) begin
      ctl.wr_en   = 1'b1;
      ctl.use_lit = 1'b1;
      unique case (instr[IW-3:IW-4])
        2'b00: ctl.op = OP_MOVL;
        2'b01: begin ctl.op = OP_IOR; ctl.upd_z = 1'b1; end
        2'b10: begin ctl.op = OP_AND; ctl.upd_z = 1'b1; end
        default: begin ctl.op = OP_XOR; ctl.upd_z = 1'b1; end
      endcase
    end else if (is_file) begin
      ctl.wr_en   = 1'b1;
      ctl.to_file = dest;
      unique case (sub_op)
        4'd0: begin
          ctl.op      = dest ? OP_MOVWF : OP_NONE;
          ctl.wr_en   = dest;
        end
        4'd1:  begin ctl.op = OP_CLR;   ctl.upd_z = 1'b1; end
        4'd2:  begin ctl.op = OP_SUB;   ctl.upd_c = 1'b1; ctl.upd_dc = 1'b1; ctl.upd_z = 1'b1; end
        4'd3:  begin ctl.op = OP_DEC;   ctl.upd_z = 1'b1; end
        4'd4:  begin ctl.op = OP_IOR;   ctl.upd_z = 1'b1; end
        4'd5:  begin ctl.op = OP_AND;   ctl.upd_z = 1'b1; end
        4'd6:  begin ctl.op = OP_XOR;   ctl.upd_z = 1'b1; end
        4'd7:  begin ctl.op = OP_ADD;   ctl.upd_c = 1'b1; ctl.upd_dc = 1'b1; ctl.upd_z = 1'b1; end
        4'd8:  begin ctl.op = OP_MOV;   ctl.upd_z = 1'b1; end
        4'd9:  begin ctl.op = OP_COM;   ctl.upd_z = 1'b1; end
        4'd10: begin ctl.op = OP_INC;   ctl.upd_z = 1'b1; end
        4'd11: begin ctl.op = OP_DECSZ; ctl.may_skip = 1'b1; end
        4'd12: begin ctl.op = OP_RRF;   ctl.upd_c = 1'b1; end
        4'd13: begin ctl.op = OP_RLF;   ctl.upd_c = 1'b1; end
        4'd14: ctl.op = OP_SWAP;
        default: begin ctl.op = OP_INCSZ; ctl.may_skip = 1'b1; end
      endcase
    end
  end

  always_comb begin
    // R2 / R3: digit carry is only ever updated together with carry
    if (ctl.upd_dc) a_r2_dc_with_c: assert (ctl.upd_c && ctl.upd_z)
      else $error("digit carry update without carry/zero");
    // R7: skip forms touch no flag
    if (ctl.may_skip) a_r7_skip_no_flags: assert (!ctl.upd_c && !ctl.upd_dc && !ctl.upd_z)
      else $error("skip form updates a flag");
    // R11: undecoded words request nothing
    if (!is_lit && !is_file) a_r11_undecoded_idle:
      assert (!ctl.wr_en && !ctl.upd_c && !ctl.upd_dc && !ctl.upd_z && !ctl.may_skip)
      else $error("undecoded word requests action");
  end
endmodule

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
  import acc_alu_pkg::*;
(
  input  op_e           op,
  input  logic [DW-1:0] w,
  input  logic [DW-1:0] f,
  output logic [DW-1:0] sum,
  output logic          c_out,
  output logic          dc_out,
  output logic          is_arith
);
  logic [DW-1:0] b_sel;
  logic          cin;
  logic [DW+1:0] packed_sum;

  always_comb begin
    b_sel    = '0;
    cin      = 1'b0;
    is_arith = 1'b1;
    unique case (op)
      OP_ADD:            begin b_sel = w;  cin = 1'b0; end
      OP_SUB:            begin b_sel = ~w; cin = 1'b1; end
      OP_INC, OP_INCSZ:  begin b_sel = '0; cin = 1'b1; end
      OP_DEC, OP_DECSZ:  begin b_sel = '1; cin = 1'b0; end
      default:           is_arith = 1'b0;
    endcase
  end

  assign packed_sum = add_carries(f, b_sel, cin);
  assign c_out      = packed_sum[DW+1];
  assign dc_out     = packed_sum[DW];
  assign sum        = packed_sum[DW-1:0];

  always_comb begin
    // R3: carry set means no borrow
    if (op == OP_SUB) a_r3_no_borrow: assert (c_out == (f >= w))
      else $error("subtract carry disagrees with f>=W");
    // R2: carry set means the true sum exceeds the byte
    if (op == OP_ADD) a_r2_add_overflow: assert (c_out == ((32'(f) + 32'(w)) > 32'(2**DW - 1)))
      else $error("add carry disagrees with overflow");
  end
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import acc_alu_pkg::*;
(
  input  op_e           op,
  input  logic [DW-1:0] w,
  input  logic [DW-1:0] x,
  input  logic          c_in,
  output logic [DW-1:0] res,
  output logic          c_rot
);
  logic [DW:0] rr;
  logic [DW:0] rl;

  assign rr = rot_right(x, c_in);
  assign rl = rot_left(x, c_in);

  always_comb begin
    res   = '0;
    c_rot = c_in;
    unique case (op)
      OP_MOVWF:        res = w;
      OP_CLR:          res = '0;
      OP_IOR:          res = w | x;
      OP_AND:          res = w & x;
      OP_XOR:          res = w ^ x;
      OP_MOV, OP_MOVL: res = x;
      OP_COM:          res = ~x;
      OP_RRF:          begin res = rr[DW-1:0]; c_rot = rr[DW]; end
      OP_RLF:          begin res = rl[DW-1:0]; c_rot = rl[DW]; end
      OP_SWAP:         res = swap_nibbles(x);
      default:         res = '0;
    endcase
  end

  always_comb begin
    // R5: rotating right then reading back recovers the operand
    if (op == OP_RRF) a_r5_rrf_lossless: assert ({res, c_rot} == {c_in, x})
      else $error("rotate right lost a bit");
    if (op == OP_RLF) a_r5_rlf_lossless: assert ({c_rot, res} == {x, c_in})
      else $error("rotate left lost a bit");
    // R6: swapping twice returns the operand
    if (op == OP_SWAP) a_r6_swap_involution: assert (swap_nibbles(res) == x)
      else $error("swap not an involution");
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
(
  input  logic [11:0] instr,
  input  logic [7:0]  w_in,
  input  logic [7:0]  f_in,
  input  logic [7:0]  status_in,
  output logic [7:0]  result,
  output logic        wr_w,
  output logic        wr_f,
  output logic [7:0]  status_out,
  output logic        skip
);
  ctl_t          ctl;
  logic [DW-1:0] operand;
  logic [DW-1:0] ar_sum;
  logic          ar_c;
  logic          ar_dc;
  logic          ar_sel;
  logic [DW-1:0] lg_res;
  logic          lg_c;
  logic          res_zero;
  logic          c_next;
  logic          dc_next;
  logic          z_next;
  logic          is_rot;

  acc_alu_decode u_decode (
    .instr (instr),
    .ctl   (ctl)
  );

  assign operand = ctl.use_lit ? instr[DW-1:0] : f_in;

  acc_alu_arith u_arith (
    .op       (ctl.op),
    .w        (w_in),
    .f        (f_in),
    .sum      (ar_sum),
    .c_out    (ar_c),
    .dc_out   (ar_dc),
    .is_arith (ar_sel)
  );

  acc_alu_logic u_logic (
    .op    (ctl.op),
    .w     (w_in),
    .x     (operand),
    .c_in  (status_in[C_BIT]),
    .res   (lg_res),
    .c_rot (lg_c)
  );

  assign result   = ar_sel ? ar_sum : lg_res;
  assign res_zero = (result == '0);
  assign is_rot   = (ctl.op == OP_RRF) || (ctl.op == OP_RLF);

  assign c_next  = !ctl.upd_c  ? status_in[C_BIT]  : (is_rot ? lg_c : ar_c);
  assign dc_next = ctl.upd_dc ? ar_dc    : status_in[DC_BIT];
  assign z_next  = ctl.upd_z  ? res_zero : status_in[Z_BIT];

  assign status_out = {{FIXED_W{1'b1}}, z_next, dc_next, c_next};
  assign wr_w       = ctl.wr_en & ~ctl.to_file;
  assign wr_f       = ctl.wr_en &  ctl.to_file;
  assign skip       = ctl.may_skip & res_zero;

  always_comb begin
    a_r1_single_dest: assert (!(wr_w && wr_f))
      else $error("both destinations written");
    a_r10_fixed_ones: assert (&status_out[DW-1:FLAG_W])
      else $error("fixed status bits not one");
    if (instr[11:10] == 2'b11) a_r8_literal_to_w: assert (wr_w && !wr_f)
      else $error("literal result not sent to W");
    if (skip) a_r7_skip_on_zero: assert (result == '0 && status_out[FLAG_W-1:0] == status_in[FLAG_W-1:0])
      else $error("skip with nonzero result or flag change");
    if (is_rot) a_r5_rot_keeps_dc_z:
      assert (status_out[Z_BIT:DC_BIT] == status_in[Z_BIT:DC_BIT])
      else $error("rotate touched digit carry or zero");
    if (instr[11:10] == 2'b01 || instr[11:10] == 2'b10) a_r11_undecoded_quiet:
      assert (!wr_w && !wr_f && !skip && status_out[FLAG_W-1:0] == status_in[FLAG_W-1:0])
      else $error("undecoded word had an effect");
  end
endmodule

// File: tb/acc_alu_tb.sv
module acc_alu_tb;
  logic        clk = 1'b0;
  logic [11:0] instr = '0;
  logic [7:0]  w_in = '0, f_in = '0, status_in = '0;
  logic [7:0]  result, status_out;
  logic        wr_w, wr_f, skip;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic       e_ww, e_wf, e_sk;
  logic [7:0] e_res, e_st;
  string      e_tag;

  always #2 clk = ~clk;

  acc_alu u_dut (
    .instr(instr), .w_in(w_in), .f_in(f_in), .status_in(status_in),
    .result(result), .wr_w(wr_w), .wr_f(wr_f), .status_out(status_out), .skip(skip)
  );

  function automatic logic [7:0] pick(input int i);
    case (i)
      0: return 8'h00;  1: return 8'h01;  2: return 8'h0F;  3: return 8'h10;
      4: return 8'h7F;  5: return 8'h80;  6: return 8'hFE;  7: return 8'hFF;
      default: return 8'((i * 53 + 7) % 256);
    endcase
  endfunction

  task automatic model(input logic [11:0] i, input logic [7:0] w, input logic [7:0] f,
                       input logic [7:0] st);
    int c, dc, z, r, s, k;
    c = st[0]; dc = st[1]; z = st[2];
    e_ww = 0; e_wf = 0; e_sk = 0; r = 0;
    if (i[11:9] >= 3'd2 && i[11:9] <= 3'd5) begin
      e_tag = "R11";
    end else if (i[11:10] == 2'b11) begin
      k = i[7:0]; e_ww = 1; e_tag = "R8";
      case (i[9:8])
        2'd0: r = k;
        2'd1: begin r = w | k; z = (r == 0); end
        2'd2: begin r = w & k; z = (r == 0); end
        default: begin r = w ^ k; z = (r == 0); end
      endcase
    end else begin
      e_ww = !i[5]; e_wf = i[5];
      case (i[9:6])
        4'd0:  begin e_tag = "R9"; e_ww = 0; e_wf = i[5]; r = w; end
        4'd1:  begin e_tag = "R4"; r = 0; z = 1; end
        4'd2:  begin e_tag = "R3"; s = f + (255 - w) + 1; r = s % 256; c = (s > 255);
                     dc = ((f % 16) + (15 - w % 16) + 1) > 15; z = (r == 0); end
        4'd7:  begin e_tag = "R2"; s = f + w; r = s % 256; c = (s > 255);
                     dc = ((f % 16) + (w % 16)) > 15; z = (r == 0); end
        4'd3:  begin e_tag = "R4"; r = (f + 255) % 256; z = (r == 0); end
        4'd4:  begin e_tag = "R4"; r = w | f; z = (r == 0); end
        4'd5:  begin e_tag = "R4"; r = w & f; z = (r == 0); end
        4'd6:  begin e_tag = "R4"; r = w ^ f; z = (r == 0); end
        4'd8:  begin e_tag = "R4"; r = f; z = (r == 0); end
        4'd9:  begin e_tag = "R4"; r = 255 - f; z = (r == 0); end
        4'd10: begin e_tag = "R4"; r = (f + 1) % 256; z = (r == 0); end
        4'd11: begin e_tag = "R7"; r = (f + 255) % 256; e_sk = (r == 0); end
        4'd15: begin e_tag = "R7"; r = (f + 1) % 256; e_sk = (r == 0); end
        4'd12: begin e_tag = "R5"; r = f / 2 + c * 128; c = f % 2; end
        4'd13: begin e_tag = "R5"; r = (f * 2) % 256 + c; c = f / 128; end
        default: begin e_tag = "R6"; r = (f % 16) * 16 + f / 16; end
      endcase
    end
    e_res = 8'(r);
    e_st  = {5'b11111, 1'(z), 1'(dc), 1'(c)};
  endtask

  task automatic compare();
    checks++;
    if (wr_w !== e_ww || wr_f !== e_wf) begin
      fails++;
      $display("FAIL R1 instr=%o wr_w/wr_f=%b%b expected %b%b", instr, wr_w, wr_f, e_ww, e_wf);
    end
    checks++;
    if (status_out[7:3] !== 5'b11111) begin
      fails++;
      $display("FAIL R10 instr=%o status_out=%h expected upper ones", instr, status_out);
    end
    checks++;
    if (status_out !== e_st || skip !== e_sk || ((e_ww || e_wf) && result !== e_res)) begin
      fails++;
      $display("FAIL %s instr=%o w=%h f=%h st=%h: res=%h st=%h skip=%b expected res=%h st=%h skip=%b",
               e_tag, instr, w_in, f_in, status_in, result, status_out, skip, e_res, e_st, e_sk);
    end
  endtask

  task automatic apply(input logic [11:0] i, input logic [7:0] w, input logic [7:0] f,
                       input logic [7:0] st);
    @(posedge clk);
    instr = i; w_in = w; f_in = f; status_in = st;
    model(i, w, f, st);
    @(negedge clk);
    compare();
  endtask

  initial begin
    // idle word: no write, no skip, flags passed through (R9, R10)
    apply(12'o0000, 8'h00, 8'h00, 8'h00);
    // borrow boundary on subtract: equal operands (R3)
    apply(12'o0240, 8'h35, 8'h35, 8'h00);
    // digit-carry boundary on add (R2)
    apply(12'o0740, 8'h0F, 8'h01, 8'h00);
    // skip wrap points (R7)
    apply(12'o1340, 8'h00, 8'h01, 8'h07);
    apply(12'o1740, 8'h00, 8'hFF, 8'h00);
    // file sweep over every opcode, both destinations, all flag inputs
    for (int op = 0; op < 16; op++)
      for (int d = 0; d < 2; d++)
        for (int wi = 0; wi < 16; wi++)
          for (int fi = 0; fi < 16; fi++)
            for (int cs = 0; cs < 8; cs++)
              apply({2'b00, 4'(op), 1'(d), 5'(fi + wi)}, pick(wi), pick(fi),
                    {5'(wi * 3 + fi), 3'(cs)});
    // literal sweep (R8)
    for (int lo = 0; lo < 4; lo++)
      for (int wi = 0; wi < 16; wi++)
        for (int kv = 0; kv < 256; kv++)
          apply({2'b11, 2'(lo), 8'(kv)}, pick(wi), pick(kv % 16), {5'(kv), 3'(kv + wi)});
    // undecoded words (R11)
    for (int top = 2; top < 6; top++)
      for (int n = 0; n < 512; n++)
        apply({3'(top), 9'((n * 97) % 512)}, pick(n % 16), pick((n / 16) % 16),
              {5'(n), 3'(n % 8)});
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int cyc = 0; cyc < 190000; cyc++) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule